// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the slave side of a very small byte-wide memory reached over a two-wire bus: one clock input and one data line that is driven in both directions. Both bus lines are sampled on a faster system clock through a synchronizer, and bus edges and start and stop conditions are found in the synchronized values. A transaction opens with a start condition. It then carries one control byte that holds the command and the word address together, and after that either a data byte to store or eight bits that the slave shifts back out.

A write is followed by a self-timed busy period. During that period the slave ignores the bus completely. Whenever the slave transmits, it drives the data line both high and low through an output-enable plus data-out pair, so the line needs no pull-up. The storage is sixteen 8-bit registers that clear on reset.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the slave does not drive the data line (sda_oe low) and every stored word reads as 0x00.
- R2: Clock pulses and data bits that arrive before any start condition (data falling while the clock is high) are ignored: no acknowledge is driven and no word changes.
- R3: After a start, the first 8 bits sampled on rising clock edges (MSB first) form the control byte, laid out as bits [7:6] command, [5:2] word address, [1:0] unused. Command 01 means write and 11 means read. Commands 00 and 10 get no acknowledge, and the slave returns to idle.
- R4: For an accepted control byte, and for each write data byte, the slave drives the line low from the falling clock edge after bit 8 until the falling edge ending the ninth clock. It does not drive while bits are being received.
- R5: A write stores the 8-bit data byte, MSB first, in the addressed word. A later read returns it.
- R6: The falling edge that ends the data acknowledge starts a busy period of WRITE_CYCLES system clocks. During that period start and stop conditions are ignored and no control byte is acknowledged. After it, the slave accepts commands again.
- R7: A read drives the addressed word MSB first. The first bit appears after the acknowledge clock falls, and each following bit appears after a falling edge. The output does not change while the clock is high. The line is released during the ninth clock after the data.
- R8: A start that arrives partway through a control byte or a write data byte abandons the transaction without storing anything, and a new control byte begins.
- R9: A stop that arrives partway through a write data byte abandons it without storing anything and without a busy period.
- R10: The two unused control bits have no effect on the command or the address.
- R11: While transmitting a read bit the slave enables its output for both 1 and 0 values (push-pull).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved level of the bus data line |
| sda_o | output | 1 | Level driven onto the data line when enabled |
| sda_oe | output | 1 | Data line output enable |

## Verification
A set of write-then-read vectors uses the lowest and highest addresses and data patterns of all ones, a single set MSB, a single set LSB and alternating bits, so bit-order and address-decoding mistakes give different results. Directed cases send each rejected command code and vary the unused bits. Start and stop conditions are inserted in the middle of the control byte and of the data byte and compared with the unchanged stored words. A read is attempted during the busy period to tell an ignored request apart from an accepted one.

// File: rtl/twe_pkg.sv
package twe_pkg;
  localparam int ADDR_W = 4;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    CMD_RSV0 = 2'b00,
    CMD_WR   = 2'b01,
    CMD_RSV1 = 2'b10,
    CMD_RD   = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ACKC, ST_DIN, ST_ACKD, ST_READ, ST_RDACK, ST_BUSY
  } st_e;

  function automatic cmd_e ctrl_cmd(input logic [CTRL_W-1:0] b);
    return cmd_e'(b[7:6]);
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_addr(input logic [CTRL_W-1:0] b);
    return b[5:2];
  endfunction

  function automatic logic cmd_accepted(input cmd_e c);
    return (c == CMD_WR) || (c == CMD_RD);
  endfunction
endpackage

// File: rtl/twe_sync_edge.sv
module twe_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_lvl;
      sda_q  <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign ev_rise  = scl_lvl & ~scl_q;
  assign ev_fall  = ~scl_lvl & scl_q;
  assign ev_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign ev_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twe_store.sv
module twe_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] word [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) word[w] <= '0;
    end else if (we) begin
      word[addr] <= wdata;
    end
  end

  assign rdata = word[addr];

  // R5: a write lands in the addressed word
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/twe_wtimer.sv
module twe_wtimer #(
  parameter int CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (go)         cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6: the busy window counts down one per system clock
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import twe_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 500000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] BIT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
  logic wt_go, wt_busy;
  logic [DATA_W-1:0] rdata;

  st_e               state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic [CTRL_W-1:0] ctrl_b;

  twe_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .ev_rise, .ev_fall, .ev_start, .ev_stop
  );

  twe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n, .we(wt_go), .addr(addr_q), .wdata(shreg), .rdata
  );

  twe_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk, .rst_n, .go(wt_go), .busy(wt_busy)
  );

  assign ctrl_b = shreg[DATA_W-1 -: CTRL_W];
  assign wt_go  = (state == ST_ACKD) && ev_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      tx_q   <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (ev_start) begin
          state <= ST_CTRL;
          cnt   <= '0;
        end
        ST_CTRL, ST_DIN: begin
          if (ev_start) begin
            state <= ST_CTRL;
            cnt   <= '0;
          end else if (ev_stop) begin
            state <= ST_IDLE;
          end else if (ev_rise && cnt != BIT_FULL) begin
            shreg <= {shreg[DATA_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (ev_fall && cnt == BIT_FULL) begin
            if (state == ST_DIN) begin
              state <= ST_ACKD;
            end else if (cmd_accepted(ctrl_cmd(ctrl_b))) begin
              state  <= ST_ACKC;
              addr_q <= ctrl_addr(ctrl_b);
              rd_q   <= (ctrl_cmd(ctrl_b) == CMD_RD);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACKC: if (ev_fall) begin
          cnt <= '0;
          if (rd_q) begin
            state <= ST_READ;
            tx_q  <= rdata;
          end else begin
            state <= ST_DIN;
          end
        end
        ST_READ: if (ev_fall) begin
          if (cnt == BIT_LAST) begin
            state <= ST_RDACK;
          end else begin
            cnt  <= cnt + 1'b1;
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
          end
        end
        ST_RDACK: if (ev_fall) state <= ST_IDLE;
        ST_ACKD:  if (ev_fall) state <= ST_BUSY;
        ST_BUSY:  if (!wt_busy) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sda_oe = 1'b0;
    sda_o  = 1'b0;
    case (state)
      ST_ACKC, ST_ACKD: sda_oe = 1'b1;
      ST_READ: begin
        sda_oe = 1'b1;
        sda_o  = tx_q[DATA_W-1];
      end
      default: ;
    endcase
  end

  // R4: an accepted control byte leads to a driven low acknowledge
  p_ack_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CTRL && ev_fall && cnt == BIT_FULL && !ev_start && !ev_stop
     && cmd_accepted(ctrl_cmd(ctrl_b))) |=> (sda_oe && !sda_o));

  // R7: the output pair never moves while the bus clock stays high
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> ($stable(sda_oe) && $stable(sda_o)));

  // R6: busy state is held while the timer runs
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && wt_busy) |=> (state == ST_BUSY));

  // R6: completing the data acknowledge arms the timer
  p_arm_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wt_go |=> (wt_busy && state == ST_BUSY));
endmodule

// File: tb/tw_eeprom_slave_tb_top.sv
module tw_eeprom_slave_tb_top;
  localparam int WRC = 400;
  localparam int H   = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_o, sda_oe, bus;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  assign bus = sda_oe ? sda_o : msda;

  tw_eeprom_slave #(.DATA_W(8), .WRITE_CYCLES(WRC), .SYNC_STAGES(2)) dut_i (
    .clk, .rst_n, .scl_i(scl), .sda_i(bus), .sda_o, .sda_oe
  );

  always #5 clk = ~clk;

  // write vectors: {addr[3:0], data[7:0]}
  localparam logic [11:0] WVEC [6] = '{12'h0A5, 12'hF3C, 12'h5FF,
                                      12'h901, 12'h380, 12'hA5A};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    msda = 1'b1; wait_h(H);
    scl  = 1'b1; wait_h(H);
    msda = 1'b0; wait_h(H);
    scl  = 1'b0; wait_h(H);
  endtask

  task automatic m_stop();
    wait_h(2); msda = 1'b0; wait_h(H);
    scl  = 1'b1; wait_h(H);
    msda = 1'b1; wait_h(H);
  endtask

  task automatic m_clk(input bit b, output bit oe_s, output bit o_s);
    wait_h(2); msda = b; wait_h(H);
    scl = 1'b1; wait_h(H);
    oe_s = sda_oe; o_s = sda_o;
    wait_h(H);
    scl = 1'b0;
  endtask

  task automatic shift_out(input logic [7:0] v, input int nbits,
                           output bit any_oe, output bit ack);
    bit oe, o;
    any_oe = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      m_clk(v[i], oe, o);
      any_oe |= oe;
    end
    ack = 1'b0;
    if (nbits == 8) begin
      m_clk(1'b1, oe, o);
      ack = oe && !o;
    end
  endtask

  task automatic write_txn(input logic [3:0] a, input logic [7:0] d, input logic [1:0] dc,
                           input bit settle, output bit ackc, output bit ackd, output bit drv);
    bit d1, d2;
    m_start();
    shift_out({2'b01, a, dc}, 8, d1, ackc);
    shift_out(d, 8, d2, ackd);
    drv = d1 | d2;
    m_stop();
    if (settle) wait_h(WRC + 40);
  endtask

  task automatic read_txn(input logic [3:0] a, input logic [1:0] dc, output logic [7:0] v,
                          output bit ackc, output bit all_drv, output bit rel);
    bit d1, oe, o;
    m_start();
    shift_out({2'b11, a, dc}, 8, d1, ackc);
    v = '0; all_drv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      m_clk(1'b1, oe, o);
      v = {v[6:0], o};
      all_drv &= oe;
    end
    m_clk(1'b1, oe, o);
    rel = !oe;
    m_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v;
    bit ackc, ackd, drv, all_drv, rel, any_oe, ack;
    wait_h(4);
    rst_n = 1'b1;
    wait_h(4);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    read_txn(4'd5, 2'b00, v, ackc, all_drv, rel);
    chk(ackc && v == 8'h00, "R1 word5 after reset", v, 0);

    // R2: bits before any start are ignored
    scl = 1'b0; wait_h(H);
    shift_out(8'h54, 8, any_oe, ack);
    chk(!any_oe && !ack, "R2 no drive before start", any_oe | ack, 0);
    shift_out(8'hEE, 8, any_oe, ack);
    chk(!any_oe && !ack, "R2 no drive on data", any_oe | ack, 0);
    m_stop();
    read_txn(4'd5, 2'b00, v, ackc, all_drv, rel);
    chk(v == 8'h00, "R2 word5 untouched", v, 0);

    // vector table: writes then read-back (R3, R4, R5, R7, R11)
    foreach (WVEC[k]) begin
      write_txn(WVEC[k][11:8], WVEC[k][7:0], 2'b00, 1'b1, ackc, ackd, drv);
      chk(ackc && ackd, "R4 write acks", {ackc, ackd}, 3);
      chk(!drv, "R4 released while receiving", drv, 0);
    end
    foreach (WVEC[k]) begin
      read_txn(WVEC[k][11:8], 2'b00, v, ackc, all_drv, rel);
      chk(ackc, "R3 read command acked", ackc, 1);
      chk(v == WVEC[k][7:0], "R5 R7 read-back", v, WVEC[k][7:0]);
      chk(all_drv, "R11 push-pull drive on every bit", all_drv, 1);
      chk(rel, "R7 released on ninth clock", rel, 1);
    end

    // R10: unused bits have no effect
    write_txn(4'd7, 8'h77, 2'b11, 1'b1, ackc, ackd, drv);
    read_txn(4'd7, 2'b10, v, ackc, all_drv, rel);
    chk(ackc && v == 8'h77, "R10 unused bits ignored", v, 8'h77);

    // R3: rejected command codes
    m_start();
    shift_out({2'b00, 4'd0, 2'b00}, 8, any_oe, ack);
    chk(!ack, "R3 command 00 not acked", ack, 0);
    m_stop();
    m_start();
    shift_out({2'b10, 4'd0, 2'b00}, 8, any_oe, ack);
    chk(!ack, "R3 command 10 not acked", ack, 0);
    m_stop();
    read_txn(4'd0, 2'b00, v, ackc, all_drv, rel);
    chk(ackc && v == 8'hA5, "R3 idle after rejection", v, 8'hA5);

    // R6: busy window ignores requests
    write_txn(4'd12, 8'hC3, 2'b00, 1'b0, ackc, ackd, drv);
    m_start();
    shift_out({2'b11, 4'd12, 2'b00}, 8, any_oe, ack);
    chk(!ack && !any_oe, "R6 no ack while busy", ack, 0);
    m_stop();
    wait_h(WRC + 40);
    read_txn(4'd12, 2'b00, v, ackc, all_drv, rel);
    chk(ackc && v == 8'hC3, "R6 accepts after busy", v, 8'hC3);

    // R8: start during write data
    m_start();
    shift_out({2'b01, 4'd3, 2'b00}, 8, any_oe, ack);
    shift_out(8'h0F, 4, any_oe, ack);
    m_start();
    shift_out({2'b01, 4'd4, 2'b00}, 8, any_oe, ackc);
    shift_out(8'h44, 8, any_oe, ackd);
    m_stop();
    wait_h(WRC + 40);
    chk(ackc && ackd, "R8 restarted write acked", {ackc, ackd}, 3);
    read_txn(4'd3, 2'b00, v, ackc, all_drv, rel);
    chk(v == 8'h80, "R8 aborted word unchanged", v, 8'h80);
    read_txn(4'd4, 2'b00, v, ackc, all_drv, rel);
    chk(v == 8'h44, "R8 new write stored", v, 8'h44);

    // R8: start during control byte
    m_start();
    shift_out(8'h40, 3, any_oe, ack);
    read_txn(4'd15, 2'b00, v, ackc, all_drv, rel);
    chk(ackc && v == 8'h3C, "R8 restart within control byte", v, 8'h3C);

    // R9: stop during write data, no busy period
    m_start();
    shift_out({2'b01, 4'd9, 2'b00}, 8, any_oe, ack);
    shift_out(8'h00, 5, any_oe, ack);
    m_stop();
    read_txn(4'd9, 2'b00, v, ackc, all_drv, rel);
    chk(ackc, "R9 no busy after stop abort", ackc, 1);
    chk(v == 8'h01, "R9 word unchanged", v, 8'h01);

    finish_run();
  end
endmodule